// File: doc/BRIEF.md
# Packed Signed Multiply with Paired Accumulate and Rounding

This block treats each 64-bit operand word as a row of packed two's-complement lanes. A select input sets the lane width to 8, 16, 32 or 64 bits. In every lane the block forms one signed product of two multiplier lanes. It adds that product to one accumulator lane and subtracts it from a second accumulator lane. The result is a butterfly pair of the kind used in transforms and filters.

Both results keep full precision until the rounding step. A right shift with round-half-up is applied to each, and the rounded value is then wrapped back into the lane. The outputs are registered once. A new operand set can therefore be issued every cycle, and its results appear one clock later.

Top module: `madd_rnd`

## Requirements
- R1: `width_sel_i` selects the lane width: 00 = 8, 01 = 16, 10 = 32, 11 = 64 bits. The word holds 64/width lanes, and lane i sits at bits [i*width+width-1 : i*width] of every operand and of both results.
- R2: Every lane of every operand is read as a signed two's-complement value of the lane width.
- R3: Before rounding, the sum-side lane value is `acc_add_i` + `mul_a_i`*`mul_b_i`. The difference-side lane value is `acc_sub_i` − `mul_a_i`*`mul_b_i`. Both are computed without loss.
- R4: For a shift n > 0, each lane result equals floor(value / 2^n + 1/2).
- R5: For a shift of zero, each lane result is the exact sum or difference.
- R6: Each lane result is the rounded value modulo 2^width. It wraps and never saturates.
- R7: The results for an input set appear on `sum_o`/`diff_o` after the next rising clock edge. While `rst_ni` is low, both outputs are zero.
- R8: Lanes are independent. No carry or borrow crosses a lane boundary.
- R9: Shift values from 0 to min(32, width)−1 are defined. Larger shift values give unspecified results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| width_sel_i | input | 2 | Lane width select |
| shamt_i | input | 5 | Rounding shift amount |
| mul_a_i | input | 64 | First multiplier lanes |
| mul_b_i | input | 64 | Second multiplier lanes |
| acc_add_i | input | 64 | Accumulator lanes that receive the product |
| acc_sub_i | input | 64 | Accumulator lanes that lose the product |
| sum_o | output | 64 | Rounded, wrapped sum lanes |
| diff_o | output | 64 | Rounded, wrapped difference lanes |

## Verification
The assertions assume that the operands, width select and shift are held steady around each rising edge. They also assume that the shift lies in the defined range for the selected width. Each property checks only the cases where the expected result is simple: a zero product, full 64-bit lanes with zero shift (sum and difference must add up to the two accumulators), and a shift of one. The stimulus changes inputs only on falling edges. It steps the shift in the defined range only, from zero in steps of min(32, width)/8.

// File: rtl/madd_rnd_pkg.sv
package madd_rnd_pkg;
  localparam int unsigned DATA_W    = 64;
  localparam int unsigned SHAMT_W   = 5;
  localparam int unsigned NUM_WSEL  = 4;
  localparam int unsigned MIN_LANE_W = 8;

  typedef enum logic [1:0] {
    LW_8  = 2'b00,
    LW_16 = 2'b01,
    LW_32 = 2'b10,
    LW_64 = 2'b11
  } lane_w_e;
endpackage

// File: rtl/madd_rnd_lane.sv
module madd_rnd_lane #(
  parameter int unsigned LW  = 8,
  parameter int unsigned SHW = 5
) (
  input  logic [LW-1:0]  a_i,
  input  logic [LW-1:0]  b_i,
  input  logic [LW-1:0]  t_i,
  input  logic [LW-1:0]  s_i,
  input  logic [SHW-1:0] shamt_i,
  output logic [LW-1:0]  sum_o,
  output logic [LW-1:0]  diff_o
);
  // 2*LW+2 keeps product, accumulate and rounding increment lossless
  localparam int unsigned XW = 2 * LW + 2;

  logic signed [XW-1:0] a_x, b_x, t_x, s_x, prod;
  logic signed [XW-1:0] sum_x, diff_x, rnd, sum_r, diff_r;

  assign a_x = {{(XW-LW){a_i[LW-1]}}, a_i};
  assign b_x = {{(XW-LW){b_i[LW-1]}}, b_i};
  assign t_x = {{(XW-LW){t_i[LW-1]}}, t_i};
  assign s_x = {{(XW-LW){s_i[LW-1]}}, s_i};

  assign prod   = b_x * a_x;
  assign sum_x  = t_x + prod;
  assign diff_x = s_x - prod;

  always_comb begin
    rnd = '0;
    if (shamt_i != '0) rnd = XW'(1) << (shamt_i - SHW'(1));
  end

  assign sum_r  = (sum_x + rnd) >>> shamt_i;
  assign diff_r = (diff_x + rnd) >>> shamt_i;

  assign sum_o  = sum_r[LW-1:0];
  assign diff_o = diff_r[LW-1:0];
endmodule

// File: rtl/madd_rnd_array.sv
module madd_rnd_array #(
  parameter int unsigned LW  = 8,
  parameter int unsigned DW  = 64,
  parameter int unsigned SHW = 5
) (
  input  logic [DW-1:0]  a_i,
  input  logic [DW-1:0]  b_i,
  input  logic [DW-1:0]  t_i,
  input  logic [DW-1:0]  s_i,
  input  logic [SHW-1:0] shamt_i,
  output logic [DW-1:0]  sum_o,
  output logic [DW-1:0]  diff_o
);
  localparam int unsigned NL = DW / LW;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    madd_rnd_lane #(.LW(LW), .SHW(SHW)) u_lane (
      .a_i     (a_i[l*LW +: LW]),
      .b_i     (b_i[l*LW +: LW]),
      .t_i     (t_i[l*LW +: LW]),
      .s_i     (s_i[l*LW +: LW]),
      .shamt_i (shamt_i),
      .sum_o   (sum_o[l*LW +: LW]),
      .diff_o  (diff_o[l*LW +: LW])
    );
  end
endmodule

// File: rtl/madd_rnd.sv
module madd_rnd
  import madd_rnd_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [1:0]           width_sel_i,
  input  logic [SHAMT_W-1:0]   shamt_i,
  input  logic [DATA_W-1:0]    mul_a_i,
  input  logic [DATA_W-1:0]    mul_b_i,
  input  logic [DATA_W-1:0]    acc_add_i,
  input  logic [DATA_W-1:0]    acc_sub_i,
  output logic [DATA_W-1:0]    sum_o,
  output logic [DATA_W-1:0]    diff_o
);
  logic [DATA_W-1:0] sum_w  [NUM_WSEL];
  logic [DATA_W-1:0] diff_w [NUM_WSEL];
  logic [DATA_W-1:0] sum_d, diff_d;

  for (genvar g = 0; g < NUM_WSEL; g++) begin : g_width
    madd_rnd_array #(
      .LW  (MIN_LANE_W << g),
      .DW  (DATA_W),
      .SHW (SHAMT_W)
    ) u_arr (
      .a_i     (mul_a_i),
      .b_i     (mul_b_i),
      .t_i     (acc_add_i),
      .s_i     (acc_sub_i),
      .shamt_i (shamt_i),
      .sum_o   (sum_w[g]),
      .diff_o  (diff_w[g])
    );
  end

  always_comb begin
    unique case (lane_w_e'(width_sel_i))
      LW_8:    begin sum_d = sum_w[0]; diff_d = diff_w[0]; end
      LW_16:   begin sum_d = sum_w[1]; diff_d = diff_w[1]; end
      LW_32:   begin sum_d = sum_w[2]; diff_d = diff_w[2]; end
      default: begin sum_d = sum_w[3]; diff_d = diff_w[3]; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o  <= '0;
      diff_o <= '0;
    end else begin
      sum_o  <= sum_d;
      diff_o <= diff_d;
    end
  end
endmodule

// File: rtl/madd_rnd_chk.sv
module madd_rnd_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [1:0]  width_sel_i,
  input logic [4:0]  shamt_i,
  input logic [63:0] mul_a_i,
  input logic [63:0] mul_b_i,
  input logic [63:0] acc_add_i,
  input logic [63:0] acc_sub_i,
  input logic [63:0] sum_o,
  input logic [63:0] diff_o
);
  // R3: full 64-bit lanes, no shift, so sum + diff = t + s
  p_pair_total_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (width_sel_i == 2'b11 && shamt_i == 5'd0)
    |=> (sum_o + diff_o) == ($past(acc_add_i) + $past(acc_sub_i)));

  // R5: zero product, zero shift passes accumulators through in any width
  p_zero_shift_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mul_a_i == 64'd0 && shamt_i == 5'd0)
    |=> (sum_o == $past(acc_add_i) && diff_o == $past(acc_sub_i)));

  // R4: shift by one rounds half up
  p_half_up_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (width_sel_i == 2'b11 && shamt_i == 5'd1 && mul_b_i == 64'd0)
    |=> sum_o == 64'(($signed($past(acc_add_i)) >>> 1) + {63'd0, $past(acc_add_i[0])}));

  // R4: difference side rounds the same way
  p_half_up_diff_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (width_sel_i == 2'b11 && shamt_i == 5'd1 && mul_b_i == 64'd0)
    |=> diff_o == 64'(($signed($past(acc_sub_i)) >>> 1) + {63'd0, $past(acc_sub_i[0])}));

  // R7: outputs cleared while reset is held
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_clear_r7: assert (sum_o == 64'd0 && diff_o == 64'd0);
    end
  end
endmodule

bind madd_rnd madd_rnd_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .width_sel_i (width_sel_i),
  .shamt_i     (shamt_i),
  .mul_a_i     (mul_a_i),
  .mul_b_i     (mul_b_i),
  .acc_add_i   (acc_add_i),
  .acc_sub_i   (acc_sub_i),
  .sum_o       (sum_o),
  .diff_o      (diff_o)
);

// File: tb/madd_rnd_tb.sv
module madd_rnd_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  wsel = 2'b00;
  logic [4:0]  shamt = 5'd0;
  logic [63:0] op_a = '0, op_b = '0, op_t = '0, op_s = '0;
  logic [63:0] sum_q, diff_q;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  madd_rnd u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .width_sel_i (wsel),
    .shamt_i     (shamt),
    .mul_a_i     (op_a),
    .mul_b_i     (op_b),
    .acc_add_i   (op_t),
    .acc_sub_i   (op_s),
    .sum_o       (sum_q),
    .diff_o      (diff_q)
  );

  // reference built from R1..R6 with wide signed integers
  function automatic logic [63:0] ref_word(input logic [1:0] sel, input logic [4:0] sh,
      input logic [63:0] a, input logic [63:0] b, input logic [63:0] c, input bit neg);
    int w = 8 << sel;
    logic [63:0] m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    logic [63:0] res = '0;
    for (int i = 0; i < 64 / w; i++) begin
      logic [63:0] la = (a >> (i * w)) & m;
      logic [63:0] lb = (b >> (i * w)) & m;
      logic [63:0] lc = (c >> (i * w)) & m;
      logic signed [129:0] xa = 130'(la);
      logic signed [129:0] xb = 130'(lb);
      logic signed [129:0] xc = 130'(lc);
      logic signed [129:0] p, v;
      if (la[w-1]) xa = xa - (130'sd1 <<< w);
      if (lb[w-1]) xb = xb - (130'sd1 <<< w);
      if (lc[w-1]) xc = xc - (130'sd1 <<< w);
      p = xa * xb;
      v = neg ? (xc - p) : (xc + p);
      if (sh != 5'd0) v = (v + (130'sd1 <<< (sh - 1))) >>> sh;
      res = res | ((64'(v) & m) << (i * w));
    end
    return res;
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h (wsel=%0d sh=%0d)", req, got, exp, wsel, shamt);
    end
  endtask

  task automatic apply(input logic [1:0] sel, input logic [4:0] sh,
      input logic [63:0] a, input logic [63:0] b, input logic [63:0] t, input logic [63:0] s);
    @(negedge clk);
    wsel = sel; shamt = sh; op_a = a; op_b = b; op_t = t; op_s = s;
    @(negedge clk);
  endtask

  task automatic apply_ref(input string req, input logic [1:0] sel, input logic [4:0] sh,
      input logic [63:0] a, input logic [63:0] b, input logic [63:0] t, input logic [63:0] s);
    apply(sel, sh, a, b, t, s);
    chk({req, " sum"}, sum_q, ref_word(sel, sh, a, b, t, 1'b0));
    chk({req, " diff"}, diff_q, ref_word(sel, sh, a, b, s, 1'b1));
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic test_reset();
    chk("R7 reset sum", sum_q, 64'd0);
    chk("R7 reset diff", diff_q, 64'd0);
  endtask

  // R1 R2 R3 R4 R6: every width, stepped shifts, 25 random sets
  task automatic test_random();
    for (int sel = 0; sel < 4; sel++) begin
      int w = 8 << sel;
      int lim = (w < 32) ? w : 32;
      for (int sh = 0; sh < lim; sh += lim / 8) begin
        for (int k = 0; k < 25; k++)
          apply_ref("R1_R3_R4_R6 random", 2'(sel), 5'(sh), rnd64(), rnd64(), rnd64(), rnd64());
      end
    end
  endtask

  // R2 R6: extreme lane values in each width
  task automatic test_extremes();
    for (int sel = 0; sel < 4; sel++) begin
      int w = 8 << sel;
      int lim = (w < 32) ? w : 32;
      logic [63:0] mn = '0, mx = '0;
      for (int i = 0; i < 64 / w; i++) begin
        mn[i*w + w - 1] = 1'b1;
        mx = mx | ((w == 64 ? 64'h7fff_ffff_ffff_ffff : ((64'd1 << (w - 1)) - 64'd1)) << (i * w));
      end
      apply_ref("R2 min*min", 2'(sel), 5'd0, mn, mn, mx, mn);
      apply_ref("R6 wrap min*min", 2'(sel), 5'(lim - 1), mn, mn, mx, mn);
      apply_ref("R2 max*min", 2'(sel), 5'd0, mx, mn, mn, mx);
      apply_ref("R6 all ones", 2'(sel), 5'(lim / 2), '1, '1, '1, '1);
    end
  endtask

  // R5: zero shift yields exact t+ab and s-ab
  task automatic test_exact();
    apply(2'b00, 5'd0, 64'h0000_0000_0000_0003, 64'h0000_0000_0000_0005,
          64'h0000_0000_0000_0001, 64'h0000_0000_0000_0001);
    chk("R5 exact sum", sum_q, 64'h0000_0000_0000_0010);
    chk("R5 exact diff", diff_q, 64'h0000_0000_0000_00f2);
  endtask

  // R4: ties round toward +inf
  task automatic test_ties();
    // 8-bit lanes, shift 1, no product: 3 -> 2, -3 -> -1, 1 -> 1, -1 -> 0
    apply(2'b00, 5'd1, 64'd0, 64'd0, 64'h0000_0000_ff01_fd03, 64'h0000_0000_0000_00fd);
    chk("R4 tie sum", sum_q, 64'h0000_0000_0001_ff02);
    chk("R4 tie diff", diff_q, 64'h0000_0000_0000_00ff);
  endtask

  // R8: carry-heavy lane 0 leaves upper lanes zero
  task automatic test_isolation();
    apply(2'b00, 5'd0, 64'h0000_0000_0000_0080, 64'h0000_0000_0000_0080,
          64'h0000_0000_0000_007f, 64'h0000_0000_0000_0080);
    chk("R8 isolate sum", sum_q, 64'h0000_0000_0000_007f);
    chk("R8 isolate diff", diff_q, 64'h0000_0000_0000_0080);
    apply_ref("R8 16-bit", 2'b01, 5'd0, 64'h0000_0000_8000_8000, 64'h0000_0000_8000_ffff,
              64'h0000_0000_7fff_7fff, 64'h0000_0000_8000_8000);
    chk("R8 upper zero", sum_q[63:32], 32'd0);
  endtask

  // R7: result appears exactly one edge after the inputs are driven
  task automatic test_latency();
    @(negedge clk);
    wsel = 2'b11; shamt = 5'd0; op_a = 64'd2; op_b = 64'd3; op_t = 64'd10; op_s = 64'd10;
    @(posedge clk); #1;
    chk("R7 latency sum", sum_q, 64'd16);
    chk("R7 latency diff", diff_q, 64'd4);
    // R9: maximum defined shift for 64-bit lanes
    apply_ref("R9 max shift", 2'b11, 5'd31, rnd64(), rnd64(), rnd64(), rnd64());
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    test_exact();
    test_ties();
    test_isolation();
    test_latency();
    test_extremes();
    test_random();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule